// File: doc/BRIEF.md
# Multi-Queue Read Port with Null Queue

This block is the read side of a small multi-queue FIFO. Thirty-two logical queues share one memory, and each queue is a fixed region of that memory with its own write pointer, read pointer and occupancy count. A write port appends words to any queue. The read port reads only from the queue that is currently selected. A strobed 5-bit select changes that queue.

A one-word prefetch stage sits between the memory and the output register. It fetches from the selected queue whenever the stage has room. As a result, a word can be taken on every clock, even when the selected queue changes while reads continue.

Queue address 31 (all ones) is reserved as the null queue. It never holds data, and writes addressed to it are discarded. Selecting it lets a word that is already in flight drain to the output. After that word is read, the read side stalls cleanly: the last word stays on the data output and the active-low valid flag is high. The null queue can stay selected for as long as needed, until another queue has data to read.

Top module: `mq_read_port`

## Requirements
- R1: Synchronous active-high reset clears every queue and selects the null queue (address 31). While in reset and after it, `out_vld_n` is 1 and `rd_data` is 0. With the null queue selected, a write to another queue does not make the output valid.
- R2: Each accepted write appends `wr_data` to queue `wr_q`. Words of one queue reach `rd_data` in the order they were written.
- R3: A queue holds at most DEPTH words. A write to a full queue is dropped, and that word is never delivered.
- R4: A write addressed to queue 31 is discarded. While queue 31 is selected, the prefetch stage never loads a word.
- R5: A select strobe is sampled on a clock edge, and fetches use the new queue from the following edge onward. A word from the old queue that is already in the prefetch stage is delivered before any word of the new queue.
- R6: `out_vld_n` is active low. While it is 0, `rd_data` holds one unconsumed word. That word is consumed at an edge where `rd_en` is 1. Without `rd_en`, the word and the flag stay unchanged.
- R7: When both queues hold data, reading on every clock across a queue switch delivers a new valid word at every edge, with no bubble.
- R8: When the selected queue (or the null queue) has nothing to deliver after a read, `out_vld_n` goes to 1. `rd_data` keeps showing the last word delivered.
- R9: `rd_en` while `out_vld_n` is 1 consumes nothing. The next word to become valid is the next word of the queue, and none is skipped.
- R10: A word written to the empty, selected queue while the pipeline is empty shows up on `rd_data` with `out_vld_n` at 0 on the second clock edge after the edge that accepted the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the read side and the write side |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_q | input | 5 | Queue written by the request (31 is the null queue) |
| wr_data | input | DATA_W | Word to append |
| rd_en | input | 1 | Consume the word currently on `rd_data` |
| sel_stb | input | 1 | Strobe that loads `sel_q` as the selected read queue |
| sel_q | input | 5 | Queue to select for reading |
| rd_data | output | DATA_W | Output register |
| out_vld_n | output | 1 | 0 when `rd_data` holds a valid, unconsumed word |

## Verification
The bench uses the default parameters: DATA_W of 16 and DEPTH of 4. A depth of four lets five writes to one queue reach the full boundary and show the dropped word. It also lets a full drain of that queue be observed within a few cycles. With 16-bit words, each queue and each position can carry a distinct tag, so a skipped, duplicated or misordered word is visible on `rd_data`. The bench also covers a queue switch while the stage is loaded, a null select with a pending word, and a null write.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // Queue addressing is fixed at 32 queues; the top index is reserved.
    localparam int unsigned Q_W    = 5;
    localparam int unsigned NUM_Q  = 1 << Q_W;
    localparam logic [Q_W-1:0] NULL_Q = '1;

    typedef logic [Q_W-1:0] qid_t;

    // Pending selection change for the read side.
    typedef struct packed {
        logic stb;
        qid_t q;
    } qsel_t;

    // Occupancy change of one queue in one cycle.
    typedef enum logic [1:0] {
        OCC_HOLD = 2'b00,
        OCC_DEC  = 2'b01,
        OCC_INC  = 2'b10,
        OCC_BOTH = 2'b11
    } occ_op_t;

    function automatic logic is_null(input qid_t q);
        return q == NULL_Q;
    endfunction

    function automatic occ_op_t occ_op(input logic push, input logic pop);
        return occ_op_t'({push, pop});
    endfunction

endpackage

// File: rtl/mq_qptrs.sv
module mq_qptrs
    import mq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned AW    = Q_W + PTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  qid_t             push_q,
    input  logic             pop,
    input  qid_t             pop_q,
    output logic [NUM_Q-1:0] q_empty,
    output logic [NUM_Q-1:0] q_full,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr
);

    logic [NUM_Q*PTR_W-1:0] wp_flat;
    logic [NUM_Q*PTR_W-1:0] rp_flat;

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
        logic             hit_w;
        logic             hit_r;

        assign hit_w = push && (push_q == qid_t'(i));
        assign hit_r = pop  && (pop_q  == qid_t'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                wp  <= '0;
                rp  <= '0;
                cnt <= '0;
            end else begin
                if (hit_w) wp <= wp + 1'b1;
                if (hit_r) rp <= rp + 1'b1;
                unique case (occ_op(hit_w, hit_r))
                    OCC_INC:  cnt <= cnt + 1'b1;
                    OCC_DEC:  cnt <= cnt - 1'b1;
                    default:  cnt <= cnt;
                endcase
            end
        end

        assign q_empty[i] = (cnt == '0);
        assign q_full[i]  = (cnt == CNT_W'(DEPTH));
        assign wp_flat[i*PTR_W +: PTR_W] = wp;
        assign rp_flat[i*PTR_W +: PTR_W] = rp;
    end

    assign wr_addr = {push_q, wp_flat[push_q*PTR_W +: PTR_W]};
    assign rd_addr = {pop_q,  rp_flat[pop_q*PTR_W +: PTR_W]};

endmodule

// File: rtl/mq_store.sv
module mq_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned AW     = 7,
    localparam int unsigned WORDS = 1 << AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mq_rdpipe.sv
module mq_rdpipe #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              fetch,
    output logic              stage_vld,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_vld_n
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t stage;
    slot_t outr;
    logic  out_free;
    logic  stage_free;

    // The output frees when empty or when its word is consumed.
    assign out_free   = !outr.vld || rd_en;
    assign stage_free = !stage.vld || out_free;
    assign fetch      = stage_free && src_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            outr  <= '0;
        end else begin
            if (out_free) begin
                outr.vld <= stage.vld;
                if (stage.vld) outr.data <= stage.data;
            end
            if (stage_free) begin
                stage.vld <= fetch;
                if (fetch) stage.data <= src_data;
            end
        end
    end

    assign stage_vld = stage.vld;
    assign rd_data   = outr.data;
    assign out_vld_n = !outr.vld;

endmodule

// File: rtl/mq_read_port.sv
module mq_read_port
    import mq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [Q_W-1:0]    wr_q,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              sel_stb,
    input  logic [Q_W-1:0]    sel_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_vld_n
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned AW    = Q_W + PTR_W;

    qsel_t             sel_in;
    qid_t              cur_q;
    logic [NUM_Q-1:0]  q_empty;
    logic [NUM_Q-1:0]  q_full;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              wr_push;
    logic              src_ready;
    logic              fetch;
    logic              pf_vld;

    assign sel_in = '{stb: sel_stb, q: sel_q};

    always_ff @(posedge clk) begin
        if (rst)             cur_q <= NULL_Q;
        else if (sel_in.stb) cur_q <= sel_in.q;
    end

    assign wr_push   = wr_en && !is_null(wr_q) && !q_full[wr_q];
    assign src_ready = !is_null(cur_q) && !q_empty[cur_q];

    mq_qptrs #(
        .DEPTH (DEPTH)
    ) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .push    (wr_push),
        .push_q  (wr_q),
        .pop     (fetch),
        .pop_q   (cur_q),
        .q_empty (q_empty),
        .q_full  (q_full),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr)
    );

    mq_store #(
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_store (
        .clk   (clk),
        .we    (wr_push),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    mq_rdpipe #(
        .DATA_W (DATA_W)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .src_ready (src_ready),
        .src_data  (mem_rdata),
        .fetch     (fetch),
        .stage_vld (pf_vld),
        .rd_data   (rd_data),
        .out_vld_n (out_vld_n)
    );

endmodule

// File: rtl/mq_read_port_chk.sv
module mq_read_port_chk
    import mq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [Q_W-1:0]    wr_q,
    input logic              rd_en,
    input logic              sel_stb,
    input logic [Q_W-1:0]    sel_q,
    input logic [DATA_W-1:0] rd_data,
    input logic              out_vld_n,
    input logic              pf_vld,
    input logic [Q_W-1:0]    cur_q,
    input logic              wr_push
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_vld_n && rd_data == '0)); // R1

    AST_NULL_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_q == NULL_Q) |-> !wr_push); // R4

    AST_NULL_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (cur_q == NULL_Q && !pf_vld) |=> !pf_vld); // R4

    AST_SEL_APPLIED: assert property (@(posedge clk) disable iff (rst)
        sel_stb |=> (cur_q == $past(sel_q))); // R5

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
        (!out_vld_n && !rd_en) |=> (!out_vld_n && $stable(rd_data))); // R6

    AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_vld_n |-> $stable(rd_data)); // R8

    AST_VALID_FROM_STAGE: assert property (@(posedge clk) disable iff (rst)
        $fell(out_vld_n) |-> $past(pf_vld)); // R10

endmodule

bind mq_read_port mq_read_port_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_q      (wr_q),
    .rd_en     (rd_en),
    .sel_stb   (sel_stb),
    .sel_q     (sel_q),
    .rd_data   (rd_data),
    .out_vld_n (out_vld_n),
    .pf_vld    (pf_vld),
    .cur_q     (cur_q),
    .wr_push   (wr_push)
);

// File: tb/tb_mq_read_port.sv
`timescale 1ns/1ps
module tb_mq_read_port;

    localparam int unsigned DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_q = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          sel_stb = 1'b0;
    logic [4:0]    sel_q = '0;
    logic [DW-1:0] rd_data;
    logic          out_vld_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mq_read_port #(.DATA_W(DW), .DEPTH(4)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
        .rd_en(rd_en), .sel_stb(sel_stb), .sel_q(sel_q),
        .rd_data(rd_data), .out_vld_n(out_vld_n)
    );

    typedef struct packed {
        logic          we;
        logic [4:0]    wq;
        logic [DW-1:0] wd;
        logic          re;
        logic          stb;
        logic [4:0]    sq;
        logic          en;
        logic [DW-1:0] ed;
    } vec_t;

    // Expected values are the outputs after the edge that samples the row.
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd1,  16'hA001, 1'b0, 1'b0, 5'd0,  1'b1, 16'h0000}, // 0  R2
        '{1'b1, 5'd1,  16'hA002, 1'b0, 1'b1, 5'd1,  1'b1, 16'h0000}, // 1  R5
        '{1'b1, 5'd2,  16'hB001, 1'b0, 1'b0, 5'd0,  1'b1, 16'h0000}, // 2
        '{1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 5'd0,  1'b0, 16'hA001}, // 3
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b1, 5'd2,  1'b0, 16'hA002}, // 4
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  1'b1, 16'hA002}, // 5  R8
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  1'b0, 16'hB001}, // 6  R9
        '{1'b1, 5'd3,  16'hC001, 1'b0, 1'b0, 5'd0,  1'b0, 16'hB001}, // 7  R6
        '{1'b1, 5'd3,  16'hC002, 1'b0, 1'b0, 5'd0,  1'b0, 16'hB001}, // 8
        '{1'b1, 5'd4,  16'hD001, 1'b0, 1'b0, 5'd0,  1'b0, 16'hB001}, // 9
        '{1'b1, 5'd4,  16'hD002, 1'b0, 1'b1, 5'd3,  1'b0, 16'hB001}, // 10
        '{1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 5'd0,  1'b0, 16'hB001}, // 11
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b1, 5'd4,  1'b0, 16'hC001}, // 12 R7
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  1'b0, 16'hC002}, // 13
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  1'b0, 16'hD001}, // 14
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b1, 5'd31, 1'b0, 16'hD002}, // 15
        '{1'b1, 5'd4,  16'hD003, 1'b1, 1'b0, 5'd0,  1'b1, 16'hD002}, // 16 R8
        '{1'b1, 5'd31, 16'hEEEE, 1'b1, 1'b0, 5'd0,  1'b1, 16'hD002}, // 17 R4
        '{1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 5'd0,  1'b1, 16'hD002}, // 18
        '{1'b0, 5'd0,  16'h0000, 1'b0, 1'b1, 5'd4,  1'b1, 16'hD002}, // 19
        '{1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 5'd0,  1'b1, 16'hD002}, // 20
        '{1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 5'd0,  1'b0, 16'hD003}, // 21
        '{1'b0, 5'd0,  16'h0000, 1'b1, 1'b0, 5'd0,  1'b1, 16'hD003}  // 22
    };

    function automatic string tag_of(input int i);
        if (i == 1 || i == 4)          return "R5";
        if (i == 6)                    return "R9";
        if (i >= 7 && i <= 11)         return "R6";
        if (i >= 12 && i <= 14)        return "R7";
        if (i == 17 || i == 18)        return "R4";
        if (i == 5 || i == 16 || i == 22) return "R8";
        return "R2";
    endfunction

    task automatic drive(input logic we, input logic [4:0] wq, input logic [DW-1:0] wd,
                         input logic re, input logic stb, input logic [4:0] sq);
        @(negedge clk);
        wr_en = we; wr_q = wq; wr_data = wd;
        rd_en = re; sel_stb = stb; sel_q = sq;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 5'd0, '0, 1'b0, 1'b0, 5'd0);
    endtask

    task automatic check(input string req, input logic en, input logic [DW-1:0] ed);
        tests++;
        if (out_vld_n !== en || (ed !== 'x && rd_data !== ed)) begin
            fails++;
            $display("FAIL %s: out_vld_n=%0b rd_data=%h expected out_vld_n=%0b rd_data=%h",
                     req, out_vld_n, rd_data, en, ed);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 0; rd_en = 0; sel_stb = 0;
        @(posedge clk); #1;
        check("R1", 1'b1, 16'h0000);
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #800000;
        tests++;
        fails++;
        $display("FAIL watchdog: out_vld_n=%0b rd_data=%h expected run to finish", out_vld_n, rd_data);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();

        // Table walk: R2, R4 to R9.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].we, VECS[i].wq, VECS[i].wd, VECS[i].re, VECS[i].stb, VECS[i].sq);
            check(tag_of(i), VECS[i].en, VECS[i].ed);
        end

        // R1: after reset the null queue is selected; data elsewhere stays hidden.
        do_reset();
        drive(1'b1, 5'd0, 16'h0F0F, 1'b0, 1'b0, 5'd0);
        idle(); idle(); idle();
        check("R1", 1'b1, 16'h0000);

        // R3: five writes to a queue of four; the fifth is dropped.
        for (int k = 0; k < 5; k++)
            drive(1'b1, 5'd5, 16'hF000 + 16'(k), 1'b0, 1'b0, 5'd0);
        drive(1'b0, 5'd0, '0, 1'b0, 1'b1, 5'd5);
        idle();
        idle();
        check("R3", 1'b0, 16'hF000);
        for (int k = 1; k < 4; k++) begin
            drive(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0);
            check("R3", 1'b0, 16'hF000 + 16'(k));
        end
        drive(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0);
        check("R3", 1'b1, 16'hF003);
        idle(); idle();
        check("R3", 1'b1, 16'hF003);

        // R10: write to the selected, empty queue.
        drive(1'b0, 5'd0, '0, 1'b0, 1'b1, 5'd7);
        idle();
        drive(1'b1, 5'd7, 16'h1234, 1'b0, 1'b0, 5'd0);
        check("R10", 1'b1, 16'hF003);
        idle();
        check("R10", 1'b1, 16'hF003);
        idle();
        check("R10", 1'b0, 16'h1234);
        drive(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0);
        check("R8", 1'b1, 16'h1234);

        // R5/R8: null select with a word pending in the stage.
        drive(1'b1, 5'd6, 16'hE001, 1'b0, 1'b0, 5'd0);
        drive(1'b1, 5'd6, 16'hE002, 1'b0, 1'b1, 5'd6);
        idle();
        idle();
        check("R6", 1'b0, 16'hE001);
        drive(1'b0, 5'd0, '0, 1'b0, 1'b1, 5'd31);
        check("R6", 1'b0, 16'hE001);
        drive(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0);
        check("R5", 1'b0, 16'hE002);
        drive(1'b0, 5'd0, '0, 1'b1, 1'b0, 5'd0);
        check("R8", 1'b1, 16'hE002);
        idle(); idle(); idle();
        check("R8", 1'b1, 16'hE002);

        // R1: reset in the middle of a run.
        drive(1'b1, 5'd6, 16'hE003, 1'b0, 1'b1, 5'd6);
        do_reset();
        idle(); idle(); idle();
        check("R1", 1'b1, 16'h0000);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule